// File: doc/BRIEF.md
# Min-Sum Soft-Bit Agglomerator for Redundancy-Free Trellis Runs

This unit shortens a run of trellis stages that carry no redundancy bit. It takes in a stream of signed information-bit log-likelihood ratios (LLRs) belonging to one such run. Each sample is sorted into one of `NUM_STATES-1` residue classes by its position in the run, modulo `NUM_STATES-1`. Every class keeps a running minimum of magnitudes and a parity of signs. This is a min-sum parity combine, interleaved across the classes. A recursion engine can then cross the whole run in `NUM_STATES-1` stages fed with the agglomerated values, plus a few zero-input stages that reorder the state metrics.

A run opens with a sample flagged `in_start` and closes with a sample flagged `in_last`. In the cycles that follow, the unit emits one agglomerated LLR per class, in class order. It then reports the number of zero-input stages the engine must append, which is the run length modulo `NUM_STATES-1`. The LLR sign convention gives a positive value to a bit that favours 0. Positions used to pad the run to a whole multiple of the class count count as a certain 0, so they never lower a minimum or flip a sign.

Top module: `llr_agg_unit`

## Requirements
- R1: The class of a sample is its position in the run (the start sample is position 0) modulo CLASSES = NUM_STATES-1 (7 by default). The magnitude of class output l is the smallest input magnitude among the samples of class l.
- R2: The sign of class output l is negative exactly when an odd number of the samples of class l are negative. An input of 0 counts as positive.
- R3: The input code -128 is read as magnitude 127. No output word is ever -128.
- R4: A class that receives no sample in the run outputs +127.
- R5: In the cycles right after the clock edge that accepts the `in_last` sample, `out_valid` is high for CLASSES consecutive cycles. During these cycles `out_idx` counts 0, 1, …, CLASSES-1 and `out_llr` carries that class's result.
- R6: In the single cycle after the last burst word, `pad_valid` is high and `pad_cnt` equals the run length modulo CLASSES. `out_valid` and `pad_valid` are never high together.
- R7: A sample that has both `in_start` and `in_valid` begins a fresh run and discards everything gathered before it. A sample that has start and last together forms a run of length 1.
- R8: Inputs are ignored while the burst or the pad report is being presented, and this includes start flags. When the unit is idle, samples without `in_start` are ignored and produce no output.
- R9: After reset, `out_valid` and `pad_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_start | input | 1 | Sample is the first of a run |
| in_last | input | 1 | Sample is the last of a run |
| in_llr | input | 8 | Two's-complement input LLR |
| out_valid | output | 1 | Agglomerated word present |
| out_idx | output | IDX_W (3) | Residue class of the word |
| out_llr | output | 8 | Agglomerated LLR |
| pad_valid | output | 1 | Pad-stage count present |
| pad_cnt | output | IDX_W (3) | Zero-input stages to append |

## Verification
A class register that is corrupted shows up as a wrong `out_llr` in that class's burst slot after the next run ends. A register that is cleared wrongly shows up as a stale minimum or a flipped sign. A fault in the residue pointer moves samples into the wrong class. Across runs of length 1 to 30 and of 101 and 102, this gives wrong words in several slots and a wrong `pad_cnt` within CLASSES+1 cycles of `in_last`. A sequencing fault breaks the index order or the pad slot at once, and samples that leak in during the drain change the words still waiting to be presented.

// File: rtl/llr_agg_pkg.sv
package llr_agg_pkg;

    localparam int LLR_W = 8;
    localparam int MAG_W = LLR_W - 1;

    typedef logic signed [LLR_W-1:0] llr_t;
    typedef logic [MAG_W-1:0]        mag_t;

    localparam mag_t MAG_MAX = '1;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } soft_t;

    localparam soft_t SOFT_ID = '{neg: 1'b0, mag: MAG_MAX};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_PAD   = 2'd3
    } agg_state_e;

    // sign / saturated magnitude split; the most negative code maps to MAG_MAX
    function automatic soft_t split_llr(input llr_t x);
        soft_t s;
        logic [LLR_W-1:0] a;
        a     = x[LLR_W-1] ? (~x + 1'b1) : x;
        s.neg = x[LLR_W-1];
        s.mag = a[LLR_W-1] ? MAG_MAX : a[MAG_W-1:0];
        return s;
    endfunction

    function automatic llr_t join_soft(input soft_t s);
        llr_t p;
        p = llr_t'({1'b0, s.mag});
        return s.neg ? -p : p;
    endfunction

    // min-sum parity combine of two soft bits
    function automatic soft_t min_sum(input soft_t a, input soft_t b);
        soft_t r;
        r.neg = a.neg ^ b.neg;
        r.mag = (a.mag < b.mag) ? a.mag : b.mag;
        return r;
    endfunction

endpackage

// File: rtl/llr_class_acc.sv
module llr_class_acc
    import llr_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  soft_t din,
    output soft_t acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= SOFT_ID;
        end else if (clr) begin
            acc <= upd ? din : SOFT_ID;
        end else if (upd) begin
            acc <= min_sum(acc, din);
        end
    end

endmodule

// File: rtl/llr_agg_ctrl.sv
module llr_agg_ctrl
    import llr_agg_pkg::*;
#(
    parameter int CLASSES = 7,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    output logic             clr_all,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic             pad_valid,
    output logic [IDX_W-1:0] pad_cnt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CLASSES - 1);

    agg_state_e       st_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] ptr_nxt;
    logic             open_st;

    assign open_st = (st_q == ST_IDLE) || (st_q == ST_RUN);
    assign wr_en   = in_valid && open_st && (in_start || (st_q == ST_RUN));
    assign clr_all = wr_en && in_start;
    assign wr_idx  = in_start ? '0 : ptr_q;
    assign ptr_nxt = (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_RUN: begin
                    if (wr_en) begin
                        ptr_q <= ptr_nxt;
                        if (in_last) begin
                            st_q  <= ST_DRAIN;
                            cnt_q <= '0;
                        end else begin
                            st_q <= ST_RUN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q == LAST_IDX) begin
                        st_q <= ST_PAD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign out_valid = (st_q == ST_DRAIN);
    assign out_idx   = cnt_q;
    assign pad_valid = (st_q == ST_PAD);
    assign pad_cnt   = ptr_q;

endmodule

// File: rtl/llr_out_mux.sv
module llr_out_mux
    import llr_agg_pkg::*;
#(
    parameter int CLASSES = 7,
    parameter int IDX_W   = 3
) (
    input  soft_t            accs [CLASSES],
    input  logic [IDX_W-1:0] sel,
    output llr_t             dout
);

    soft_t pick;

    always_comb begin
        pick = SOFT_ID;
        for (int i = 0; i < CLASSES; i++) begin
            if (sel == IDX_W'(i)) pick = accs[i];
        end
    end

    assign dout = join_soft(pick);

endmodule

// File: rtl/llr_agg_unit.sv
module llr_agg_unit
    import llr_agg_pkg::*;
#(
    parameter int NUM_STATES = 8,
    localparam int CLASSES   = NUM_STATES - 1,
    localparam int IDX_W     = (CLASSES > 1) ? $clog2(CLASSES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    input  logic [7:0]       in_llr,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [7:0]       out_llr,
    output logic             pad_valid,
    output logic [IDX_W-1:0] pad_cnt
);

    logic             clr_all;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    soft_t            din;
    soft_t            accs [CLASSES];
    llr_t             mux_out;

    assign din = split_llr(llr_t'(in_llr));

    llr_agg_ctrl #(.CLASSES(CLASSES), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_last   (in_last),
        .clr_all   (clr_all),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .pad_valid (pad_valid),
        .pad_cnt   (pad_cnt)
    );

    for (genvar g = 0; g < CLASSES; g++) begin : g_cls
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        llr_class_acc u_acc (
            .clk (clk),
            .rst (rst),
            .clr (clr_all),
            .upd (hit),
            .din (din),
            .acc (accs[g])
        );
    end

    llr_out_mux #(.CLASSES(CLASSES), .IDX_W(IDX_W)) u_mux (
        .accs (accs),
        .sel  (out_idx),
        .dout (mux_out)
    );

    assign out_llr = mux_out;

endmodule

// File: rtl/llr_agg_chk.sv
module llr_agg_chk #(
    parameter int CLASSES = 7,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic [IDX_W-1:0] out_idx,
    input logic [7:0]       out_llr,
    input logic             pad_valid,
    input logic [IDX_W-1:0] pad_cnt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CLASSES - 1);

    // R5
    burst_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx != LAST_IDX) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    // R5
    burst_begin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_idx == '0));

    // R6
    pad_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == LAST_IDX) |=> (pad_valid && !out_valid));

    // R6
    pad_range_chk: assert property (@(posedge clk) disable iff (rst)
        pad_valid |-> (pad_cnt < IDX_W'(CLASSES)));

    // R6
    pad_once_chk: assert property (@(posedge clk) disable iff (rst)
        pad_valid |=> !pad_valid);

    // R6
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && pad_valid));

    // R3
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_llr != 8'h80));

endmodule

bind llr_agg_unit llr_agg_chk #(.CLASSES(CLASSES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_llr   (out_llr),
    .pad_valid (pad_valid),
    .pad_cnt   (pad_cnt)
);

// File: tb/llr_agg_unit_tb.sv
module llr_agg_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 8;
    localparam int C          = NS - 1;
    localparam int IW         = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_start, in_last;
    logic [7:0]    in_llr;
    logic          out_valid, pad_valid;
    logic [IW-1:0] out_idx, pad_cnt;
    logic [7:0]    out_llr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int smp [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    llr_agg_unit #(.NUM_STATES(NS)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_llr(in_llr), .out_valid(out_valid),
        .out_idx(out_idx), .out_llr(out_llr), .pad_valid(pad_valid),
        .pad_cnt(pad_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int mode, input int i);
        case (mode)
            0: return int'($urandom_range(255)) - 128;
            1: return -128;
            2: return 0;
            3: return ((i * 37 + 11) % 256) - 128;
            default: return (i % 2 == 0) ? 5 + i : -(3 + i);
        endcase
    endfunction

    task automatic idle_in();
        in_valid = 0; in_start = 0; in_last = 0; in_llr = '0;
    endtask

    // drives n samples from smp[], then checks burst and pad report
    task automatic apply_run(input int n, input bit junk);
        int emag [C];
        bit eneg [C];
        for (int l = 0; l < C; l++) begin emag[l] = 127; eneg[l] = 0; end
        for (int i = 0; i < n; i++) begin
            int v, a;
            v = smp[i];
            a = (v < 0) ? -v : v;
            if (a > 127) a = 127;
            if (a < emag[i % C]) emag[i % C] = a;
            if (v < 0) eneg[i % C] = ~eneg[i % C];
            in_valid = 1; in_start = (i == 0); in_last = (i == n - 1);
            in_llr = 8'(v);
            @(negedge clk);
        end
        if (junk) begin
            in_valid = 1; in_start = 1; in_last = 1; in_llr = 8'h81;
        end else begin
            idle_in();
        end
        for (int k = 0; k < C; k++) begin
            int e, act;
            e   = eneg[k] ? -emag[k] : emag[k];
            act = int'($signed(out_llr));
            // R1 R2 R3 R4 R5 R8: burst word k
            check(out_valid && out_idx == IW'(k) && act == e,
                  $sformatf("R1/R2/R3/R4/R5/R8 n=%0d class=%0d", n, k), act, e);
            @(negedge clk);
        end
        // R6: pad count
        check(pad_valid && !out_valid && int'(pad_cnt) == n % C,
              $sformatf("R6 n=%0d pad", n), int'(pad_cnt), n % C);
        idle_in();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        check(!out_valid, "R9 out_valid", int'(out_valid), 0);
        check(!pad_valid, "R9 pad_valid", int'(pad_valid), 0);

        // R8: idle samples without start give no output
        for (int i = 0; i < 5; i++) begin
            in_valid = 1; in_start = 0; in_last = 1; in_llr = 8'h90;
            @(negedge clk);
            check(!out_valid && !pad_valid, "R8 idle no start", int'(out_valid), 0);
        end
        idle_in();
        @(negedge clk);

        // R1 R2 R4 R6: length sweep, mixed patterns, junk during drain (R8)
        for (int n = 1; n <= 30; n++) begin
            for (int i = 0; i < n; i++) smp[i] = gen(n % 5, i);
            apply_run(n, n[0]);
        end

        // R3: all most-negative codes
        for (int i = 0; i < 14; i++) smp[i] = -128;
        apply_run(14, 0);
        // R2: all zeros count as positive
        for (int i = 0; i < 9; i++) smp[i] = 0;
        apply_run(9, 0);
        // long runs typical of the 8-state code
        for (int i = 0; i < 101; i++) smp[i] = gen(0, i);
        apply_run(101, 1);
        for (int i = 0; i < 102; i++) smp[i] = gen(3, i);
        apply_run(102, 0);

        // R7: restart mid-run discards earlier samples
        for (int i = 0; i < 6; i++) begin
            in_valid = 1; in_start = (i == 0); in_last = 0; in_llr = 8'h81;
            @(negedge clk);
        end
        for (int i = 0; i < 10; i++) smp[i] = 60 + i;
        apply_run(10, 0);
        // R7: start and last together
        smp[0] = -77;
        apply_run(1, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule